// File: doc/BRIEF.md
# Warp Issue Scheduler for a SIMD Multiprocessor

This block keeps the bookkeeping for the thread groups resident on one SIMD multiprocessor and chooses, every clock cycle, at most one warp to send to the core array. A thread block arrives as a single admission request carrying its thread count. The block is accepted whole or not at all. On acceptance it receives a block identifier and is cut into warps of 32 consecutive thread indices. Each warp takes one warp slot from a fixed pool.

Each cycle the scheduler looks at three things: the per-slot operand-ready inputs from the scoreboard, the barrier arrivals and the completion pulses. From these it picks the next ready warp in round-robin order, so that switching between warps costs no cycle. Warps that wait at a barrier are held until every warp of their own block has arrived. When every warp of a block has completed, the block's slots and identifier return to the pool.

Top module: `ws_warp_sched`

## Requirements
- R1: After reset no slot is occupied, `iss_valid` is low, and a request for 1 to 32 threads sees `adm_ready` high with `adm_id` 0.
- R2: At most one warp issues per cycle. An issued slot is occupied, not waiting at a barrier, not done, and has its `warp_ready` bit high.
- R3: `iss_valid` is low only when no occupied slot is ready, not waiting and not done.
- R4: The issued slot is the first eligible slot found by searching upward, with wrap-around, from the slot after the previously issued one. After reset the search starts at slot 0.
- R5: `adm_ready` is high exactly when all of the following hold: the thread count lies in 1..512, a block identifier is free, and the free slots number at least ceil(count/32). A request with `adm_valid` high then takes the lowest free identifier. It also takes the lowest-numbered free slots in ascending order, and warp k of the block occupies the k-th of those slots.
- R6: `iss_mask` is all ones for a full warp. For the last warp of a block whose count leaves remainder r (not 0) modulo 32, it has only bits r-1..0 set.
- R7: A `bar_hit` bit marks its slot as waiting from the next cycle on, but only if the slot is occupied, not waiting and not done. On any other slot it has no effect.
- R8: A block is released when it has at least one waiting warp, every one of its warps is waiting or done, and not all of its warps are done. On release, its waiting flags clear at the next edge. Warps of other blocks are not affected.
- R9: A `done_hit` bit marks an occupied slot done. Once all warps of a block are done, its slots and identifier are freed at the next edge and can be admitted in the cycle after that.
- R10: `iss_blk` gives the block identifier of the issued warp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adm_valid | input | 1 | Block admission request |
| adm_threads | input | 10 | Thread count of the requested block |
| adm_ready | output | 1 | Request fits now (combinational on the request) |
| adm_id | output | 3 | Identifier given to the block if it is accepted |
| warp_ready | input | 24 | Per-slot operand-ready flags from the scoreboard |
| bar_hit | input | 24 | Per-slot barrier arrival pulse |
| done_hit | input | 24 | Per-slot completion pulse |
| iss_valid | output | 1 | A warp is issued this cycle |
| iss_slot | output | 5 | Slot index of the issued warp |
| iss_blk | output | 3 | Block identifier of the issued warp |
| iss_mask | output | 32 | Lane-valid mask of the issued warp |

## Verification
The bench focuses on three areas. The first is the round-robin pointer across wrap-around and across cycles with no issue: a pointer that moved on an idle cycle would skip a warp. The second is barrier release when some warps of the block are already done: a design that waited for done warps to arrive would deadlock the block, and one that counted arrivals across blocks would free the wrong block early. The third is admission at the limits. This covers thread counts of 0 and 513, the ninth block, and a block one warp larger than the free pool. It also covers reuse of freed slots exactly one cycle after retirement: an early reuse would hand out slots that are still occupied, and a late reuse would stall admission. Partial last warps are compared lane by lane, and a wrong remainder shows up as extra or missing mask bits.

// File: rtl/ws_pkg.sv
package ws_pkg;

  // per-slot status bundle
  typedef struct packed {
    logic live;
    logic waiting;
    logic done;
  } ws_flags_t;

  // number of warps needed for a thread count
  function automatic int warps_for(input int thr, input int lanes);
    return (thr + lanes - 1) / lanes;
  endfunction

endpackage

// File: rtl/ws_rr_pick.sv
module ws_rr_pick #(
  parameter int N  = 24,
  parameter int IW = 5
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (int'(last) + k) % N;
      if (!found && req[j]) begin
        found = 1'b1;
        idx   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/ws_slot_alloc.sv
module ws_slot_alloc #(
  parameter int N  = 24,
  parameter int CW = 5
) (
  input  logic [N-1:0]  busy,
  input  logic [CW-1:0] need,
  output logic [N-1:0]  take,
  output logic [N-1:0]  take_last,
  output logic [CW-1:0] free_cnt
);
  always_comb begin
    int cnt;
    cnt       = 0;
    take      = '0;
    take_last = '0;
    for (int i = 0; i < N; i++) begin
      if (!busy[i] && cnt < int'(need)) begin
        take[i]      = 1'b1;
        take_last[i] = (cnt == int'(need) - 1);
        cnt          = cnt + 1;
      end
    end
  end

  always_comb begin
    free_cnt = '0;
    for (int i = 0; i < N; i++) free_cnt = free_cnt + CW'(!busy[i]);
  end
endmodule

// File: rtl/ws_blk_eval.sv
module ws_blk_eval #(
  parameter int NS = 24,
  parameter int NB = 8,
  parameter int BW = 3
) (
  input  logic [NS-1:0] live,
  input  logic [NS-1:0] waiting,
  input  logic [NS-1:0] done,
  input  logic [BW-1:0] blk_of [NS],
  input  logic [NB-1:0] blk_busy,
  output logic [NB-1:0] release_b,
  output logic [NB-1:0] retire_b
);
  logic [NB-1:0] all_arr, all_done, any_wait;

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      all_arr[b]  = 1'b1;
      all_done[b] = 1'b1;
      any_wait[b] = 1'b0;
      for (int i = 0; i < NS; i++) begin
        if (live[i] && int'(blk_of[i]) == b) begin
          if (!(waiting[i] || done[i])) all_arr[b] = 1'b0;
          if (!done[i])                 all_done[b] = 1'b0;
          if (waiting[i])               any_wait[b] = 1'b1;
        end
      end
      release_b[b] = blk_busy[b] && all_arr[b] && any_wait[b] && !all_done[b];
      retire_b[b]  = blk_busy[b] && all_done[b];
    end
  end
endmodule

// File: rtl/ws_warp_sched.sv
module ws_warp_sched #(
  parameter int NUM_SLOTS   = 24,
  parameter int MAX_BLKS    = 8,
  parameter int LANES       = 32,
  parameter int MAX_THREADS = 512
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 adm_valid,
  input  logic [$clog2(MAX_THREADS+1)-1:0]     adm_threads,
  output logic                                 adm_ready,
  output logic [$clog2(MAX_BLKS)-1:0]          adm_id,
  input  logic [NUM_SLOTS-1:0]                 warp_ready,
  input  logic [NUM_SLOTS-1:0]                 bar_hit,
  input  logic [NUM_SLOTS-1:0]                 done_hit,
  output logic                                 iss_valid,
  output logic [$clog2(NUM_SLOTS)-1:0]         iss_slot,
  output logic [$clog2(MAX_BLKS)-1:0]          iss_blk,
  output logic [LANES-1:0]                     iss_mask
);
  import ws_pkg::*;

  localparam int SW = $clog2(NUM_SLOTS);
  localparam int BW = $clog2(MAX_BLKS);
  localparam int LW = $clog2(LANES);
  localparam int CW = $clog2(NUM_SLOTS + 1);

  ws_flags_t           flg_q [NUM_SLOTS];
  ws_flags_t           flg_d [NUM_SLOTS];
  logic [BW-1:0]       blk_q [NUM_SLOTS];
  logic [BW-1:0]       blk_d [NUM_SLOTS];
  logic [LW-1:0]       tail_q[NUM_SLOTS];
  logic [LW-1:0]       tail_d[NUM_SLOTS];
  logic [MAX_BLKS-1:0] bbusy_q, bbusy_d;
  logic [SW-1:0]       last_q;

  logic [NUM_SLOTS-1:0] live_v, wait_v, done_v, elig, take, take_last;
  logic [MAX_BLKS-1:0]  rel_b, ret_b;
  logic [CW-1:0]        need, free_cnt;
  logic                 size_ok, blk_free, accept;

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      live_v[i] = flg_q[i].live;
      wait_v[i] = flg_q[i].waiting;
      done_v[i] = flg_q[i].done;
    end
  end

  assign elig = live_v & ~wait_v & ~done_v & warp_ready;

  ws_rr_pick #(.N(NUM_SLOTS), .IW(SW)) u_pick (
    .req(elig), .last(last_q), .found(iss_valid), .idx(iss_slot));

  ws_blk_eval #(.NS(NUM_SLOTS), .NB(MAX_BLKS), .BW(BW)) u_eval (
    .live(live_v), .waiting(wait_v), .done(done_v), .blk_of(blk_q),
    .blk_busy(bbusy_q), .release_b(rel_b), .retire_b(ret_b));

  // admission sizing
  assign size_ok = (adm_threads != '0) && (int'(adm_threads) <= MAX_THREADS);
  assign need    = size_ok ? CW'(warps_for(int'(adm_threads), LANES)) : '0;

  ws_slot_alloc #(.N(NUM_SLOTS), .CW(CW)) u_alloc (
    .busy(live_v), .need(need), .take(take), .take_last(take_last),
    .free_cnt(free_cnt));

  always_comb begin
    blk_free = 1'b0;
    adm_id   = '0;
    for (int b = MAX_BLKS - 1; b >= 0; b--) begin
      if (!bbusy_q[b]) begin
        blk_free = 1'b1;
        adm_id   = BW'(b);
      end
    end
  end

  assign adm_ready = size_ok && blk_free && (free_cnt >= need);
  assign accept    = adm_valid && adm_ready;

  // issue outputs
  assign iss_blk  = blk_q[iss_slot];
  assign iss_mask = (tail_q[iss_slot] == '0) ? '1 :
                    (({{(LANES-1){1'b0}}, 1'b1} << tail_q[iss_slot]) - 1'b1);

  // next state
  always_comb begin
    bbusy_d = (bbusy_q & ~ret_b);
    if (accept) bbusy_d[adm_id] = 1'b1;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      flg_d[i]  = flg_q[i];
      blk_d[i]  = blk_q[i];
      tail_d[i] = tail_q[i];
      if (flg_q[i].live) begin
        flg_d[i].waiting = (flg_q[i].waiting && !rel_b[blk_q[i]]) ||
                           (bar_hit[i] && !flg_q[i].waiting && !flg_q[i].done);
        flg_d[i].done    = flg_q[i].done || done_hit[i];
        if (ret_b[blk_q[i]]) flg_d[i] = '0;
      end else if (accept && take[i]) begin
        flg_d[i]  = '{live: 1'b1, waiting: 1'b0, done: 1'b0};
        blk_d[i]  = adm_id;
        tail_d[i] = take_last[i] ? adm_threads[LW-1:0] : '0;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bbusy_q <= '0;
      last_q  <= SW'(NUM_SLOTS - 1);
      for (int i = 0; i < NUM_SLOTS; i++) begin
        flg_q[i]  <= '0;
        blk_q[i]  <= '0;
        tail_q[i] <= '0;
      end
    end else begin
      bbusy_q <= bbusy_d;
      if (iss_valid) last_q <= iss_slot;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        flg_q[i] <= flg_d[i];
        if (accept && take[i]) begin
          blk_q[i]  <= blk_d[i];
          tail_q[i] <= tail_d[i];
        end
      end
    end
  end

  // R2
  iss_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (warp_ready[iss_slot] && live_v[iss_slot] && !wait_v[iss_slot] && !done_v[iss_slot]));

  // R3
  no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(live_v & ~wait_v & ~done_v & warp_ready)) |-> iss_valid);

  // R5
  adm_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adm_valid && adm_ready) |-> ($countones(take) == int'(need) && $countones(take & live_v) == 0));

  // R9
  retire_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ret_b) |=> ((bbusy_q & $past(ret_b)) == '0));

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot_chk
      // R7
      bar_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_hit[g] && live_v[g] && !wait_v[g] && !done_v[g] && !ret_b[blk_q[g]]) |=> wait_v[g]);
    end
  endgenerate

endmodule

// File: tb/sim_ws_warp_sched.sv
module sim_ws_warp_sched;
  localparam int CLK_P = 10;
  localparam int NS = 24, NB = 8, LN = 32, MT = 512;

  logic        clk, rst_n, adm_valid, adm_ready, iss_valid;
  logic [9:0]  adm_threads;
  logic [2:0]  adm_id, iss_blk;
  logic [23:0] warp_ready, bar_hit, done_hit;
  logic [4:0]  iss_slot;
  logic [31:0] iss_mask;

  int checks = 0, errors = 0;

  // reference state
  int m_live[NS], m_wait[NS], m_done[NS], m_blk[NS], m_tail[NS];
  int m_bbusy[NB];
  int m_last;
  // expected outputs
  int e_valid, e_slot, e_blk, e_ready, e_id;
  logic [31:0] e_mask;

  ws_warp_sched u0 (
    .clk(clk), .rst_n(rst_n), .adm_valid(adm_valid), .adm_threads(adm_threads),
    .adm_ready(adm_ready), .adm_id(adm_id), .warp_ready(warp_ready),
    .bar_hit(bar_hit), .done_hit(done_hit), .iss_valid(iss_valid),
    .iss_slot(iss_slot), .iss_blk(iss_blk), .iss_mask(iss_mask));

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NS; i++) begin
      m_live[i] = 0; m_wait[i] = 0; m_done[i] = 0; m_blk[i] = 0; m_tail[i] = 0;
    end
    for (int b = 0; b < NB; b++) m_bbusy[b] = 0;
    m_last = NS - 1;
  endtask

  // expected outputs for current inputs, then advance the model one edge
  task automatic model_step();
    int need, freec, fb, thr;
    int rel[NB], ret[NB];
    int old_live[NS];
    thr  = int'(adm_threads);
    need = (thr + LN - 1) / LN;
    freec = 0;
    for (int i = 0; i < NS; i++) if (m_live[i] == 0) freec++;
    fb = -1;
    for (int b = NB - 1; b >= 0; b--) if (m_bbusy[b] == 0) fb = b;
    e_ready = (thr >= 1 && thr <= MT && fb >= 0 && freec >= need) ? 1 : 0;
    e_id    = (fb < 0) ? 0 : fb;
    e_valid = 0; e_slot = 0;
    for (int k = 1; k <= NS; k++) begin
      int j;
      j = (m_last + k) % NS;
      if (e_valid == 0 && m_live[j] != 0 && m_wait[j] == 0 && m_done[j] == 0 && warp_ready[j]) begin
        e_valid = 1; e_slot = j;
      end
    end
    e_blk  = m_blk[e_slot];
    e_mask = (m_tail[e_slot] == 0) ? 32'hFFFF_FFFF : ((32'h1 << m_tail[e_slot]) - 32'h1);
    // block conditions
    for (int b = 0; b < NB; b++) begin
      int arr, alld, anyw;
      arr = 1; alld = 1; anyw = 0;
      for (int i = 0; i < NS; i++) if (m_live[i] != 0 && m_blk[i] == b) begin
        if (m_wait[i] == 0 && m_done[i] == 0) arr = 0;
        if (m_done[i] == 0) alld = 0;
        if (m_wait[i] != 0) anyw = 1;
      end
      rel[b] = (m_bbusy[b] != 0 && arr != 0 && anyw != 0 && alld == 0) ? 1 : 0;
      ret[b] = (m_bbusy[b] != 0 && alld != 0) ? 1 : 0;
    end
    for (int i = 0; i < NS; i++) old_live[i] = m_live[i];
    for (int i = 0; i < NS; i++) if (m_live[i] != 0) begin
      int nw;
      nw = ((m_wait[i] != 0 && rel[m_blk[i]] == 0) ||
            (bar_hit[i] && m_wait[i] == 0 && m_done[i] == 0)) ? 1 : 0;
      m_done[i] = (m_done[i] != 0 || done_hit[i]) ? 1 : 0;
      m_wait[i] = nw;
      if (ret[m_blk[i]] != 0) begin
        m_live[i] = 0; m_wait[i] = 0; m_done[i] = 0;
      end
    end
    for (int b = 0; b < NB; b++) if (ret[b] != 0) m_bbusy[b] = 0;
    if (adm_valid && e_ready != 0) begin
      int cnt;
      cnt = 0;
      for (int i = 0; i < NS; i++) if (old_live[i] == 0 && cnt < need) begin
        m_live[i] = 1; m_wait[i] = 0; m_done[i] = 0; m_blk[i] = fb;
        m_tail[i] = (cnt == need - 1) ? (thr % LN) : 0;
        cnt++;
      end
      m_bbusy[fb] = 1;
    end
    if (e_valid != 0) m_last = e_slot;
  endtask

  // inputs already driven after a falling edge
  task automatic cycle_cmp();
    #1;
    model_step();
    check("R5 adm_ready", adm_ready, e_ready);
    if (e_ready != 0) check("R5 adm_id", adm_id, e_id);
    check("R3 iss_valid", iss_valid, e_valid);
    if (e_valid != 0) begin
      check("R4 iss_slot", iss_slot, e_slot);
      check("R10 iss_blk", iss_blk, e_blk);
      check("R6 iss_mask", iss_mask, e_mask);
    end
    @(negedge clk);
  endtask

  task automatic drive(input logic av, input int thr, input logic [23:0] rdy,
                       input logic [23:0] bh, input logic [23:0] dh);
    adm_valid = av; adm_threads = 10'(thr); warp_ready = rdy; bar_hit = bh; done_hit = dh;
    cycle_cmp();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; adm_valid = 1'b0; adm_threads = 10'd32;
    warp_ready = '0; bar_hit = '0; done_hit = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 iss_valid", iss_valid, 0);
    check("R1 adm_ready", adm_ready, 1);
    check("R1 adm_id", adm_id, 0);
    @(negedge clk);
    // R5 illegal sizes rejected
    adm_threads = 10'd0;   #1; check("R5 zero threads", adm_ready, 0);
    adm_threads = 10'd513; #1; check("R5 513 threads", adm_ready, 0);
    adm_threads = 10'd512; #1; check("R5 512 threads", adm_ready, 1);
    @(negedge clk);
    // R5 admit 100 threads and R6 partial warp
    drive(1'b1, 100, '0, '0, '0);
    drive(1'b0, 64, '1, '0, '0);
    check("R4 first slot", iss_slot, 1);
    drive(1'b0, 64, '1, '0, '0);
    drive(1'b0, 64, '1, '0, '0);
    #1; check("R6 tail mask", iss_mask, 32'h0000_000F); check("R4 slot3", iss_slot, 3);
    drive(1'b0, 64, '1, '0, '0);
    // R7 barrier on slot 0 and 1, then slots 2,3 done -> R8 release
    drive(1'b0, 64, 24'h00000F, 24'h000003, '0);
    drive(1'b0, 64, 24'h00000F, '0, 24'h00000C);
    drive(1'b0, 64, 24'h00000F, '0, '0);
    drive(1'b0, 64, 24'h00000F, '0, '0);
    // R7 bar_hit on empty slot ignored
    drive(1'b0, 64, 24'hFFFFFF, 24'hFF0000, '0);
    // R9 finish block 0, readmit next cycle
    drive(1'b0, 64, '0, '0, 24'h000003);
    drive(1'b1, 512, '0, '0, '0);
    drive(1'b1, 512, '0, '0, '0);
    drive(1'b1, 257, '0, '0, '0);
    drive(1'b1, 32, 24'hFFFFFF, '0, '0);
    // random traffic
    for (int c = 0; c < 4000; c++) begin
      logic [23:0] r, bh, dh;
      int thr, sel;
      for (int i = 0; i < NS; i++) begin
        r[i]  = ($urandom_range(0, 3) != 0);
        bh[i] = ($urandom_range(0, 29) == 0);
        dh[i] = ($urandom_range(0, 39) == 0);
      end
      sel = $urandom_range(0, 19);
      thr = (sel == 0) ? 0 : (sel == 1) ? 513 : (sel < 8) ? $urandom_range(1, 64)
            : $urandom_range(1, 512);
      drive($urandom_range(0, 2) == 0, thr, r, bh, dh);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule